// File: doc/BRIEF.md
# Multi-Domain Software Reset Sequencer

This block takes one software-writable reset control bit and fans it out as a reset pulse into several independent clock domains, for example a system-bus domain and separate transmit-line and receive-line domains. A write of 1 on the register interface starts a sequence. The request level is carried into each domain through a synchronizer. Each domain then drives its own reset output high for a fixed number of its own clock cycles and raises a release acknowledge. The acknowledges are synchronized back into the register domain.

The readable status bit reads 1 from the cycle after the starting write until the whole sequence is over. The sequence is over only when every domain has released its reset and the four-phase request/acknowledge handshake has returned to rest. Software therefore polls the status bit for 0 before it reprograms anything. Completion time follows the slowest domain clock. A domain whose clock is absent keeps the bit set for as long as the clock stays away.

The control and status pins are plain levels and strobes. There is no stream interface and no back-pressure. The rest of the register file and the logic being reset lie outside this block.

Top module: `mdrst_sequencer`

## Requirements
- R1: After the register-domain reset `rst_reg_n` is released, `cfg_busy` reads 0, every `dom_rst` bit is 0 and every `dom_done` bit is 0.
- R2: A register-clock cycle with `cfg_wr`=1 and `cfg_wdata`=1 while `cfg_busy` is 0 makes `cfg_busy` read 1 from the next register-clock cycle.
- R3: For each request, every domain reset output `dom_rst[i]` goes high exactly once and stays high for exactly HOLD_CYCLES (default 4) consecutive cycles of `dom_clk[i]`.
- R4: `cfg_busy` falls only after every `dom_rst` bit has returned low. When it falls, all `dom_done` bits are 0.
- R5: `cfg_busy` returns to 0 by itself once all domains are done, with no further write by software.
- R6: While any domain clock is stopped, `cfg_busy` stays 1 regardless of how long the stop lasts. The sequence then completes once that clock runs again.
- R7: The time from the starting write to `cfg_busy` falling is at least (SYNC_STAGES + HOLD_CYCLES) periods of the slowest domain clock.
- R8: A write of 1 while `cfg_busy` is 1 is ignored: it causes no second reset pulse in any domain and does not restart the sequence.
- R9: A write with `cfg_wdata`=0 has no effect: it causes no reset pulse and does not set `cfg_busy`.
- R10: `dom_done[i]` is the release acknowledge of domain i as seen in the register domain. It is never 1 while `dom_rst[i]` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_reg | input | 1 | Register-domain clock |
| rst_reg_n | input | 1 | Active-low asynchronous power-on reset for all flops of the block |
| cfg_wr | input | 1 | Write strobe for the reset control bit |
| cfg_wdata | input | 1 | Data bit written with `cfg_wr`; 1 requests a reset |
| cfg_busy | output | 1 | Status readback: 1 while a reset sequence is in progress |
| dom_clk | input | NUM_DOM | One clock per controlled domain |
| dom_rst | output | NUM_DOM | Active-high reset per domain, synchronous to its `dom_clk` |
| dom_done | output | NUM_DOM | Per-domain release acknowledge, synchronized to `clk_reg` |

## Verification
The hardest situation to reach from the ports is a domain clock that stops in the middle of a sequence and then returns. The bench gates one domain clock off right after the request and holds the status bit under observation for hundreds of register cycles. It then restarts that clock and expects a single, correctly sized pulse together with completion. The dependence on clock ratio comes from a sweep over a grid of half-periods for two of the domains. Completion time is measured against a bound derived from the slowest period. Alternate sweep points add writes of 1 and 0 in the middle of a sequence.

// File: rtl/mdrst_pkg.sv
package mdrst_pkg;

  typedef enum logic [1:0] {
    CTL_IDLE    = 2'd0,
    CTL_ASSERT  = 2'd1,
    CTL_RELEASE = 2'd2
  } ctl_state_t;

  typedef enum logic [1:0] {
    DOM_IDLE = 2'd0,
    DOM_HOLD = 2'd1,
    DOM_DONE = 2'd2
  } dom_state_t;

endpackage

// File: rtl/mdrst_sync.sv
module mdrst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  input  logic d,
  output logic q
);
  localparam int LAST = STAGES - 1;

  logic [LAST:0] chain;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk or negedge arst_n)
        if (!arst_n) chain <= '0;
        else         chain <= d;
    end else begin : g_multi
      always_ff @(posedge clk or negedge arst_n)
        if (!arst_n) chain <= '0;
        else         chain <= {chain[LAST-1:0], d};
    end
  endgenerate

  assign q = chain[LAST];
endmodule

// File: rtl/mdrst_domain.sv
module mdrst_domain
  import mdrst_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int HOLD_CYCLES = 4
) (
  input  logic clk_d,
  input  logic arst_n,
  input  logic req_i,
  output logic rst_o,
  output logic ack_o
);
  localparam int CW = $clog2(HOLD_CYCLES + 1);
  localparam logic [CW-1:0] LOAD = CW'(HOLD_CYCLES - 1);

  logic       req_s;
  dom_state_t st;
  logic [CW-1:0] cnt;

  mdrst_sync #(.STAGES(SYNC_STAGES)) u_req_sync (
    .clk(clk_d), .arst_n(arst_n), .d(req_i), .q(req_s)
  );

  always_ff @(posedge clk_d or negedge arst_n) begin
    if (!arst_n) begin
      st    <= DOM_IDLE;
      cnt   <= '0;
      rst_o <= 1'b0;
      ack_o <= 1'b0;
    end else begin
      unique case (st)
        DOM_IDLE: if (req_s) begin
          st    <= DOM_HOLD;
          cnt   <= LOAD;
          rst_o <= 1'b1;
        end
        DOM_HOLD: if (cnt == '0) begin
          st    <= DOM_DONE;
          rst_o <= 1'b0;
          ack_o <= 1'b1;
        end else begin
          cnt <= cnt - 1'b1;
        end
        DOM_DONE: if (!req_s) begin
          st    <= DOM_IDLE;
          ack_o <= 1'b0;
        end
        default: st <= DOM_IDLE;
      endcase
    end
  end

  // R10: reset and acknowledge are never high together
  a_r10_no_ack_in_reset: assert property (@(posedge clk_d) disable iff (!arst_n)
    !(rst_o && ack_o));
  // R3: a pulse starts only from a synchronized request
  a_r3_pulse_needs_req: assert property (@(posedge clk_d) disable iff (!arst_n)
    $rose(rst_o) |-> $past(req_s));
  // R3: the end of a pulse raises the acknowledge
  a_r3_release_acks: assert property (@(posedge clk_d) disable iff (!arst_n)
    $fell(rst_o) |-> ack_o);
endmodule

// File: rtl/mdrst_ctrl.sv
module mdrst_ctrl
  import mdrst_pkg::*;
#(
  parameter int NUM_DOM     = 3,
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               arst_n,
  input  logic               wr_i,
  input  logic               wdata_i,
  input  logic [NUM_DOM-1:0] ack_i,
  output logic               req_o,
  output logic               busy_o,
  output logic [NUM_DOM-1:0] ack_s_o
);
  ctl_state_t st, st_nx;
  logic [NUM_DOM-1:0] ack_s;

  for (genvar i = 0; i < NUM_DOM; i++) begin : g_ack
    mdrst_sync #(.STAGES(SYNC_STAGES)) u_ack_sync (
      .clk(clk), .arst_n(arst_n), .d(ack_i[i]), .q(ack_s[i])
    );
  end

  always_comb begin
    st_nx = st;
    unique case (st)
      CTL_IDLE:    if (wr_i && wdata_i) st_nx = CTL_ASSERT;
      CTL_ASSERT:  if (&ack_s)          st_nx = CTL_RELEASE;
      CTL_RELEASE: if (~|ack_s)         st_nx = CTL_IDLE;
      default:                          st_nx = CTL_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      st     <= CTL_IDLE;
      req_o  <= 1'b0;
      busy_o <= 1'b0;
    end else begin
      st     <= st_nx;
      req_o  <= (st_nx == CTL_ASSERT);
      busy_o <= (st_nx != CTL_IDLE);
    end
  end

  assign ack_s_o = ack_s;

  // R2: an accepted request shows as busy on the next cycle
  a_r2_busy_after_write: assert property (@(posedge clk) disable iff (!arst_n)
    (!busy_o && wr_i && wdata_i) |=> busy_o);
  // R9: a zero write while idle leaves the block idle
  a_r9_zero_write_inert: assert property (@(posedge clk) disable iff (!arst_n)
    (!busy_o && wr_i && !wdata_i) |=> !busy_o);
  // R4: busy falls only once every acknowledge has returned to rest
  a_r4_fall_after_handshake: assert property (@(posedge clk) disable iff (!arst_n)
    $fell(busy_o) |-> (ack_s == '0));
  // R8: a running sequence never jumps back to idle while requesting
  a_r8_no_restart: assert property (@(posedge clk) disable iff (!arst_n)
    (st == CTL_ASSERT) |=> (st != CTL_IDLE));
endmodule

// File: rtl/mdrst_sequencer.sv
module mdrst_sequencer #(
  parameter int NUM_DOM     = 3,
  parameter int SYNC_STAGES = 2,
  parameter int HOLD_CYCLES = 4
) (
  input  logic               clk_reg,
  input  logic               rst_reg_n,
  input  logic               cfg_wr,
  input  logic               cfg_wdata,
  output logic               cfg_busy,
  input  logic [NUM_DOM-1:0] dom_clk,
  output logic [NUM_DOM-1:0] dom_rst,
  output logic [NUM_DOM-1:0] dom_done
);
  logic               req;
  logic [NUM_DOM-1:0] ack;

  mdrst_ctrl #(.NUM_DOM(NUM_DOM), .SYNC_STAGES(SYNC_STAGES)) u_ctrl (
    .clk(clk_reg), .arst_n(rst_reg_n), .wr_i(cfg_wr), .wdata_i(cfg_wdata),
    .ack_i(ack), .req_o(req), .busy_o(cfg_busy), .ack_s_o(dom_done)
  );

  for (genvar i = 0; i < NUM_DOM; i++) begin : g_dom
    mdrst_domain #(.SYNC_STAGES(SYNC_STAGES), .HOLD_CYCLES(HOLD_CYCLES)) u_dom (
      .clk_d(dom_clk[i]), .arst_n(rst_reg_n), .req_i(req),
      .rst_o(dom_rst[i]), .ack_o(ack[i])
    );
  end
endmodule

// File: tb/mdrst_sequencer_test.sv
module mdrst_sequencer_test;
  localparam int ND = 3;
  localparam int HOLD = 4;
  localparam int SYNC = 2;

  logic clk_reg = 1'b0;
  logic rst_reg_n = 1'b0;
  logic cfg_wr = 1'b0, cfg_wdata = 1'b0;
  logic cfg_busy;
  logic dclk0 = 1'b0, dclk1 = 1'b0, dclk2 = 1'b0;
  logic [ND-1:0] dclk, dom_rst, dom_done;
  int hp0 = 4, hp1 = 5, hp2 = 7;
  bit en0 = 1, en1 = 1, en2 = 1;

  int n_chk = 0, n_bad = 0;
  int pulses [ND];
  int cur_len [ND];
  int last_len [ND];

  assign dclk = {dclk2, dclk1, dclk0};

  always #4 clk_reg = ~clk_reg;
  always begin #(hp0); if (en0) dclk0 = ~dclk0; end
  always begin #(hp1); if (en1) dclk1 = ~dclk1; end
  always begin #(hp2); if (en2) dclk2 = ~dclk2; end

  mdrst_sequencer #(.NUM_DOM(ND), .SYNC_STAGES(SYNC), .HOLD_CYCLES(HOLD)) uut (
    .clk_reg(clk_reg), .rst_reg_n(rst_reg_n), .cfg_wr(cfg_wr), .cfg_wdata(cfg_wdata),
    .cfg_busy(cfg_busy), .dom_clk(dclk), .dom_rst(dom_rst), .dom_done(dom_done)
  );

  initial for (int g = 0; g < ND; g++) begin pulses[g] = 0; cur_len[g] = 0; last_len[g] = 0; end

  for (genvar g = 0; g < ND; g++) begin : mon
    always @(negedge dclk[g]) begin
      if (dom_rst[g]) cur_len[g] = cur_len[g] + 1;
      else if (cur_len[g] > 0) begin
        last_len[g] = cur_len[g];
        pulses[g] = pulses[g] + 1;
        cur_len[g] = 0;
      end
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    #3000000;
    chk(1'b0, "watchdog", 0, 1);
    finish_run();
  end

  // Starts one sequence; optionally injects writes while busy; stops domain 1 if asked.
  task automatic run_seq(input bit inject, input bit stall);
    int base [ND];
    int t0, t_end, slow, cyc;
    bit overlap_bad;
    for (int g = 0; g < ND; g++) base[g] = pulses[g];
    slow = hp0; if (hp1 > slow) slow = hp1; if (hp2 > slow) slow = hp2;
    @(negedge clk_reg);
    cfg_wr = 1'b1; cfg_wdata = 1'b1;
    t0 = int'($time);
    @(negedge clk_reg);
    cfg_wr = 1'b0;
    chk(cfg_busy == 1'b1, "R2", int'(cfg_busy), 1);
    if (stall) begin
      en1 = 0;
      repeat (400) @(negedge clk_reg);
      chk(cfg_busy == 1'b1, "R6 stalled", int'(cfg_busy), 1);
      en1 = 1;
    end
    overlap_bad = 0;
    cyc = 0;
    while (cfg_busy && cyc < 20000) begin
      if (inject && cyc == 3)  begin cfg_wr = 1'b1; cfg_wdata = 1'b1; end
      if (inject && cyc == 4)  begin cfg_wr = 1'b0; end
      if (inject && cyc == 40) begin cfg_wr = 1'b1; cfg_wdata = 1'b1; end
      if (inject && cyc == 41) begin cfg_wr = 1'b1; cfg_wdata = 1'b0; end
      if (inject && cyc == 42) begin cfg_wr = 1'b0; end
      if ((dom_done & dom_rst) != '0) overlap_bad = 1;
      @(negedge clk_reg);
      cyc++;
    end
    cfg_wr = 1'b0;
    t_end = int'($time);
    chk(!cfg_busy, "R5 self-clear", int'(cfg_busy), 0);
    chk(dom_rst == '0, "R4 resets low", int'(dom_rst), 0);
    chk(dom_done == '0, "R4 done idle", int'(dom_done), 0);
    chk(!overlap_bad, "R10 done vs reset", int'(overlap_bad), 0);
    chk((t_end - t0) >= 2*slow*(SYNC+HOLD), "R7 min time", t_end - t0, 2*slow*(SYNC+HOLD));
    for (int g = 0; g < ND; g++) begin
      chk(pulses[g] - base[g] == 1, inject ? "R8 one pulse" : "R3 one pulse", pulses[g] - base[g], 1);
      chk(last_len[g] == HOLD, "R3 width", last_len[g], HOLD);
    end
    repeat (5) @(negedge clk_reg);
  endtask

  int opts [5] = '{3, 5, 9, 17, 29};

  initial begin
    int base0 [ND];
    repeat (3) @(negedge clk_reg);
    rst_reg_n = 1'b1;
    repeat (3) @(negedge clk_reg);
    chk(!cfg_busy, "R1 busy", int'(cfg_busy), 0);
    chk(dom_rst == '0, "R1 dom_rst", int'(dom_rst), 0);
    chk(dom_done == '0, "R1 dom_done", int'(dom_done), 0);

    // R9: zero write while idle
    for (int g = 0; g < ND; g++) base0[g] = pulses[g];
    @(negedge clk_reg);
    cfg_wr = 1'b1; cfg_wdata = 1'b0;
    @(negedge clk_reg);
    cfg_wr = 1'b0;
    chk(!cfg_busy, "R9 busy", int'(cfg_busy), 0);
    repeat (60) @(negedge clk_reg);
    chk(!cfg_busy, "R9 busy later", int'(cfg_busy), 0);
    for (int g = 0; g < ND; g++)
      chk(pulses[g] == base0[g] && dom_rst[g] == 1'b0, "R9 no pulse", pulses[g] - base0[g], 0);

    // Clock-ratio sweep (R3, R4, R5, R7, R8, R10)
    for (int i = 0; i < 5; i++) begin
      for (int j = 0; j < 5; j++) begin
        hp1 = opts[i];
        hp2 = opts[j];
        repeat (4) @(negedge clk_reg);
        run_seq(((i + j) % 2) == 1, 1'b0);
      end
    end

    // R6: stalled domain clock
    hp1 = 9; hp2 = 5;
    repeat (4) @(negedge clk_reg);
    run_seq(1'b0, 1'b1);

    finish_run();
  end
endmodule